// File: doc/BRIEF.md
# Stallable Raster Sync Master

This block produces the raster timing of a digital video bus when it is the sync master. The outputs are horizontal sync, vertical sync, an odd/even field flag and a composite blank. It runs on a double-rate clock and moves forward only on cycles where a half-rate clock-enable is high. A pixel-valid qualifier with selectable polarity can stall it at any point. While it is stalled, every raster counter holds its position.

Eight 12-bit timing registers are loaded through a single-cycle write port. They set the line length, the frame height, the active window in both directions and the two sync pulse widths. When the master-select input is low, the block is a slave. It then holds its counters, pulls its output-enable low and forces the timing outputs to zero, so that another source can drive the bus.

Top module: `raster_sync_master`

## Requirements
- R1: While rst_ni is low, sync_oe_o is 0 and hsync_o, vsync_o, field_o and blank_o are 0. After release, the horizontal counter, vertical counter and field flag all start at zero, and the timing registers hold their parameter defaults.
- R2: The counters move forward only on a rising clock edge where clk_en_i is 1. With clk_en_i at 0 the raster position does not change.
- R3: The pixel-valid input counts as active when pvalid_i equals pvalid_pol_i. On an enabled edge where it is inactive, the horizontal counter, vertical counter and field flag all hold.
- R4: Each line lasts h_total advances. The horizontal position runs 0 to h_total-1 and then wraps to 0. hsync_o is 1 while the position is below h_sync_w.
- R5: Each time a line wraps, the line counter steps. It runs 0 to v_total-1 and then wraps to 0. vsync_o is 1 while the line is below v_sync_w.
- R6: blank_o is the OR of a horizontal blank and a vertical blank. The horizontal blank is 1 outside the range h_act_start ≤ position < h_act_end. The vertical blank is 1 outside the range v_act_start ≤ line < v_act_end.
- R7: The internal field flag starts at 0 (even) and inverts when the raster wraps from the last line to line 0, which is where the vertical sync pulse begins. field_o is the flag XOR fi_pol_i.
- R8: With master_i at 0, sync_oe_o is 0, all four timing outputs are 0 and the counters hold. With master_i at 1 and reset released, sync_oe_o is 1.
- R9: A write with cfg_we_i at 1 loads cfg_wdata_i into the register selected by cfg_addr_i at that edge. The register map is: 0 = h_total, 1 = h_act_start, 2 = h_act_end, 3 = h_sync_w, 4 = v_total, 5 = v_act_start, 6 = v_act_end, 7 = v_sync_w. The counter update at the same edge still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate video clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Half-rate advance enable |
| master_i | input | 1 | 1 = sync master, 0 = slave (outputs released) |
| pvalid_i | input | 1 | Pixel-valid qualifier |
| pvalid_pol_i | input | 1 | Active level of pvalid_i |
| fi_pol_i | input | 1 | Field flag output inversion |
| cfg_we_i | input | 1 | Timing register write strobe |
| cfg_addr_i | input | 3 | Timing register select |
| cfg_wdata_i | input | 12 | Timing register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| field_o | output | 1 | Odd/even field flag after polarity |
| blank_o | output | 1 | Composite blank |
| sync_oe_o | output | 1 | Output-enable for the timing outputs |

## Verification
A wrong counter value shows up at the ports within the same advance. An off-by-one position moves the hsync or blank edges one pixel, and a missed freeze during a stall moves every later edge. A vertical counter or field flag that is wrong inside a line may stay hidden until the next line wrap or frame wrap. The bench therefore runs several whole frames under each stimulus pattern. It compares every cycle against a reference raster model, so a fault shows up at most one frame after it occurs.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
  localparam int CNT_W  = 12;
  localparam int ADDR_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [ADDR_W-1:0] {
    REG_H_TOTAL = 3'd0,
    REG_H_ACT_S = 3'd1,
    REG_H_ACT_E = 3'd2,
    REG_H_SYNC  = 3'd3,
    REG_V_TOTAL = 3'd4,
    REG_V_ACT_S = 3'd5,
    REG_V_ACT_E = 3'd6,
    REG_V_SYNC  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    cnt_t h_total;
    cnt_t h_act_s;
    cnt_t h_act_e;
    cnt_t h_sync;
    cnt_t v_total;
    cnt_t v_act_s;
    cnt_t v_act_e;
    cnt_t v_sync;
  } timing_cfg_t;
endpackage

// File: rtl/raster_cfg_regs.sv
`timescale 1ns/1ps
module raster_cfg_regs
  import raster_pkg::*;
#(
  parameter timing_cfg_t RST_CFG = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  cnt_t              wdata_i,
  output timing_cfg_t       cfg_o
);
  timing_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RST_CFG;
    end else if (we_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_H_TOTAL: cfg_q.h_total <= wdata_i;
        REG_H_ACT_S: cfg_q.h_act_s <= wdata_i;
        REG_H_ACT_E: cfg_q.h_act_e <= wdata_i;
        REG_H_SYNC:  cfg_q.h_sync  <= wdata_i;
        REG_V_TOTAL: cfg_q.v_total <= wdata_i;
        REG_V_ACT_S: cfg_q.v_act_s <= wdata_i;
        REG_V_ACT_E: cfg_q.v_act_e <= wdata_i;
        REG_V_SYNC:  cfg_q.v_sync  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  a_r9_hsync_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_H_SYNC) |=> cfg_q.h_sync == $past(wdata_i));
  a_r9_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/raster_counters.sv
`timescale 1ns/1ps
module raster_counters
  import raster_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clk_en_i,
  input  logic        master_i,
  input  logic        pvalid_i,
  input  logic        pvalid_pol_i,
  input  timing_cfg_t cfg_i,
  output cnt_t        h_cnt_o,
  output cnt_t        v_cnt_o,
  output logic        field_o
);
  cnt_t h_cnt_q, v_cnt_q;
  logic field_q;
  logic adv, h_last, v_last;

  // pixel-valid active when it matches the programmed level
  assign adv    = clk_en_i & master_i & ~(pvalid_i ^ pvalid_pol_i);
  assign h_last = h_cnt_q >= cnt_t'(cfg_i.h_total - 1'b1);
  assign v_last = v_cnt_q >= cnt_t'(cfg_i.v_total - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt_q <= '0;
      v_cnt_q <= '0;
      field_q <= 1'b0;
    end else if (adv) begin
      if (h_last) begin
        h_cnt_q <= '0;
        if (v_last) begin
          v_cnt_q <= '0;
          field_q <= ~field_q;
        end else begin
          v_cnt_q <= v_cnt_q + 1'b1;
        end
      end else begin
        h_cnt_q <= h_cnt_q + 1'b1;
      end
    end
  end

  assign h_cnt_o = h_cnt_q;
  assign v_cnt_o = v_cnt_q;
  assign field_o = field_q;

  a_r2_hold_without_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(h_cnt_q) && $stable(v_cnt_q) && $stable(field_q));
  a_r3_freeze_on_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pvalid_i != pvalid_pol_i) |=> $stable(h_cnt_q) && $stable(v_cnt_q) && $stable(field_q));
  a_r4_line_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && master_i && pvalid_i == pvalid_pol_i &&
     h_cnt_q >= cnt_t'(cfg_i.h_total - 1'b1)) |=> h_cnt_q == '0);
  a_r7_field_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && master_i && pvalid_i == pvalid_pol_i &&
     h_cnt_q >= cnt_t'(cfg_i.h_total - 1'b1) &&
     v_cnt_q >= cnt_t'(cfg_i.v_total - 1'b1)) |=> field_q != $past(field_q));
  a_r8_slave_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> $stable(h_cnt_q) && $stable(v_cnt_q));
endmodule

// File: rtl/raster_decode.sv
`timescale 1ns/1ps
module raster_decode
  import raster_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        master_i,
  input  logic        fi_pol_i,
  input  timing_cfg_t cfg_i,
  input  cnt_t        h_cnt_i,
  input  cnt_t        v_cnt_i,
  input  logic        field_i,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        field_o,
  output logic        blank_o,
  output logic        oe_o
);
  logic hs, vs, hb, vb;

  assign hs = h_cnt_i < cfg_i.h_sync;
  assign vs = v_cnt_i < cfg_i.v_sync;
  assign hb = !((h_cnt_i >= cfg_i.h_act_s) && (h_cnt_i < cfg_i.h_act_e));
  assign vb = !((v_cnt_i >= cfg_i.v_act_s) && (v_cnt_i < cfg_i.v_act_e));

  // released bus reads as zero with enable low
  assign oe_o    = master_i & rst_ni;
  assign hsync_o = oe_o & hs;
  assign vsync_o = oe_o & vs;
  assign field_o = oe_o & (field_i ^ fi_pol_i);
  assign blank_o = oe_o & (hb | vb);

  a_r8_released_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !oe_o && !hsync_o && !vsync_o && !field_o && !blank_o);
  a_r6_blank_covers_sync_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && vsync_o && cfg_i.v_act_s >= cfg_i.v_sync) |-> blank_o);
  a_r1_reset_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> oe_o);
endmodule

// File: rtl/raster_sync_master.sv
`timescale 1ns/1ps
module raster_sync_master
  import raster_pkg::*;
#(
  parameter int unsigned H_TOTAL = 858,
  parameter int unsigned H_ACT_S = 138,
  parameter int unsigned H_ACT_E = 858,
  parameter int unsigned H_SYNC  = 62,
  parameter int unsigned V_TOTAL = 263,
  parameter int unsigned V_ACT_S = 20,
  parameter int unsigned V_ACT_E = 260,
  parameter int unsigned V_SYNC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              master_i,
  input  logic              pvalid_i,
  input  logic              pvalid_pol_i,
  input  logic              fi_pol_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              blank_o,
  output logic              sync_oe_o
);
  localparam timing_cfg_t RST_CFG = '{
    h_total: cnt_t'(H_TOTAL), h_act_s: cnt_t'(H_ACT_S),
    h_act_e: cnt_t'(H_ACT_E), h_sync:  cnt_t'(H_SYNC),
    v_total: cnt_t'(V_TOTAL), v_act_s: cnt_t'(V_ACT_S),
    v_act_e: cnt_t'(V_ACT_E), v_sync:  cnt_t'(V_SYNC)
  };

  timing_cfg_t cfg;
  cnt_t        h_cnt, v_cnt;
  logic        field_q;

  raster_cfg_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  raster_counters u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clk_en_i     (clk_en_i),
    .master_i     (master_i),
    .pvalid_i     (pvalid_i),
    .pvalid_pol_i (pvalid_pol_i),
    .cfg_i        (cfg),
    .h_cnt_o      (h_cnt),
    .v_cnt_o      (v_cnt),
    .field_o      (field_q)
  );

  raster_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .fi_pol_i (fi_pol_i),
    .cfg_i    (cfg),
    .h_cnt_i  (h_cnt),
    .v_cnt_i  (v_cnt),
    .field_i  (field_q),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .field_o  (field_o),
    .blank_o  (blank_o),
    .oe_o     (sync_oe_o)
  );
endmodule

// File: tb/raster_sync_master_tb.sv
`timescale 1ns/1ps
module raster_sync_master_tb;
  localparam int W = 12;
  localparam logic [W-1:0] D_HT = 12, D_HS = 3, D_HE = 10, D_HW = 2;
  localparam logic [W-1:0] D_VT = 5,  D_VS = 1, D_VE = 4,  D_VW = 1;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 0, master = 1, pv = 1, pv_pol = 1, fi_pol = 0;
  logic we = 0;
  logic [2:0] addr = 0;
  logic [W-1:0] wdata = 0;
  logic hs_o, vs_o, fld_o, blk_o, oe_o;

  always #4 clk = ~clk;

  raster_sync_master #(
    .H_TOTAL(D_HT), .H_ACT_S(D_HS), .H_ACT_E(D_HE), .H_SYNC(D_HW),
    .V_TOTAL(D_VT), .V_ACT_S(D_VS), .V_ACT_E(D_VE), .V_SYNC(D_VW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .master_i(master),
    .pvalid_i(pv), .pvalid_pol_i(pv_pol), .fi_pol_i(fi_pol),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .hsync_o(hs_o), .vsync_o(vs_o), .field_o(fld_o), .blank_o(blk_o),
    .sync_oe_o(oe_o)
  );

  typedef struct {
    logic [4:0] v; // oe hs vs fld blk
    string      req;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] cfg [8];
  logic [W-1:0] hc, vc;
  logic fq;

  function automatic logic [4:0] model_out();
    logic hsx, vsx, hbx, vbx;
    if (!master) return 5'b0;
    hsx = hc < cfg[3];
    vsx = vc < cfg[7];
    hbx = !(hc >= cfg[1] && hc < cfg[2]);
    vbx = !(vc >= cfg[5] && vc < cfg[6]);
    return {1'b1, hsx, vsx, fq ^ fi_pol, hbx | vbx};
  endfunction

  task automatic step(input logic e, input logic p, input logic m,
                      input logic w, input logic [2:0] a, input logic [W-1:0] d,
                      input string req);
    exp_t it;
    @(negedge clk);
    en = e; pv = p; master = m; we = w; addr = a; wdata = d;
    if (e && m && (p == pv_pol)) begin
      if (hc >= W'(cfg[0] - 1'b1)) begin
        hc = '0;
        if (vc >= W'(cfg[4] - 1'b1)) begin vc = '0; fq = ~fq; end
        else vc = vc + 1'b1;
      end else hc = hc + 1'b1;
    end
    if (w) cfg[a] = d;
    it.v = model_out();
    it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    logic [4:0] got;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        got = {oe_o, hs_o, vs_o, fld_o, blk_o};
        checks++;
        if (got !== it.v) begin
          errors++;
          $display("FAIL %s oe/hs/vs/fld/blk got %b exp %b at %0t", it.req, got, it.v, $time);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    cfg[0] = D_HT; cfg[1] = D_HS; cfg[2] = D_HE; cfg[3] = D_HW;
    cfg[4] = D_VT; cfg[5] = D_VS; cfg[6] = D_VE; cfg[7] = D_VW;
    hc = 0; vc = 0; fq = 0;
    // R1: outputs released and zero during reset
    repeat (3) @(negedge clk);
    checks++;
    if ({oe_o, hs_o, vs_o, fld_o, blk_o} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs got %b exp 00000", {oe_o, hs_o, vs_o, fld_o, blk_o});
    end
    repeat (6) @(negedge clk);
    rst_n = 1;
    // R1: counters start at zero with default timing
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, 0, "R1");
    // R2: half-rate enable over two default frames
    for (int i = 0; i < 2 * 12 * 5 * 2; i++) step(i[0], 1, 1, 0, 0, 0, "R2");
    // R9: program a new raster, enable low
    step(0, 1, 1, 1, 3'd0, 12'd10, "R9");
    step(0, 1, 1, 1, 3'd1, 12'd2,  "R9");
    step(0, 1, 1, 1, 3'd2, 12'd8,  "R9");
    step(0, 1, 1, 1, 3'd3, 12'd1,  "R9");
    step(0, 1, 1, 1, 3'd4, 12'd6,  "R9");
    step(0, 1, 1, 1, 3'd5, 12'd1,  "R9");
    step(0, 1, 1, 1, 3'd6, 12'd5,  "R9");
    step(0, 1, 1, 1, 3'd7, 12'd2,  "R9");
    // R4 R5 R6: full frames with the new raster
    for (int i = 0; i < 2 * 10 * 6 * 2; i++) step(i[0], 1, 1, 0, 0, 0, "R4");
    // R2: irregular enable
    for (int i = 0; i < 150; i++) step(1'($urandom), 1, 1, 0, 0, 0, "R2");
    // R3: random stalls, active-high qualifier
    for (int i = 0; i < 250; i++) step(i[0], 1'($urandom), 1, 0, 0, 0, "R3");
    // R3: active-low qualifier
    @(negedge clk); pv_pol = 0;
    for (int i = 0; i < 250; i++) step(i[0], 1'($urandom), 1, 0, 0, 0, "R3");
    // R3: held inactive level freezes the raster
    for (int i = 0; i < 40; i++) step(1, 1, 1, 0, 0, 0, "R3");
    // R7: inverted field polarity across frame wraps
    @(negedge clk); fi_pol = 1;
    for (int i = 0; i < 300; i++) step(i[0], 0, 1, 0, 0, 0, "R7");
    // R8: slave mode releases outputs and holds the raster
    for (int i = 0; i < 60; i++) step(i[0], 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 60; i++) step(i[0], 0, 1, 0, 0, 0, "R8");
    // R9: shrink the line mid-frame while advancing
    step(1, 0, 1, 1, 3'd0, 12'd4, "R9");
    for (int i = 0; i < 120; i++) step(i[0], 0, 1, 0, 0, 0, "R9");
    // R6: blank window change
    step(0, 0, 1, 1, 3'd2, 12'd3, "R6");
    step(0, 0, 1, 1, 3'd6, 12'd3, "R6");
    for (int i = 0; i < 100; i++) step(i[0], 0, 1, 0, 0, 0, "R6");
    // R5: longer vertical sync
    step(0, 0, 1, 1, 3'd7, 12'd4, "R5");
    for (int i = 0; i < 100; i++) step(1, 0, 1, 0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule